// File: doc/BRIEF.md
# Register Write-Protect Unlock Gate

This block guards the configuration registers of a flash controller on a 32-bit memory-mapped bus. It owns the control register, whose protect flag decides whether writes to the controller's registers take effect. Each bus write is judged in the cycle it appears. The block raises `accept_o` when the write takes effect. It drops the write and records a sticky error when protection forbids it.

The protect flag can only be changed after a three-word key sequence on two unlock registers. This holds in both directions, so clearing protection needs the keys and so does setting it again. A completed sequence arms exactly one control-register write. That write may change every control bit, including the flag, and the gate then closes again.

The sequencer, timing registers and flash array behind the gate are not part of this block. They see only the accept decision and the exposed control value.

Top module: `regbank_wp_gate`

## Requirements
- R1: After reset the control register reads 0x002 (protect flag, bit 1, set), the error flag is clear, and the key tracker is idle, so a control write without keys is blocked.
- R2: While bit 1 of control is 1, writes to control (0x00), timing (0x04, 0x08, 0x0C), address (0x20), buffer data (0x24) and buffer index (0x28) are dropped and `accept_o` is low. Control is dropped only when not armed. With bit 1 at 0, these writes are accepted.
- R3: A dropped write sets status bit 1 (`wp_err_o`), which stays set until cleared.
- R4: Writing status (0x2C) is never blocked. A 1 in data bit 1 clears the error flag, and a 0 there leaves it unchanged.
- R5: Writing 0x00007123 to 0x18, then 0x0000812A to 0x1C, then 0x0000BEE1 to 0x18 arms the gate. The next control write is accepted and loads all stored bits, including bit 1.
- R6: A control write that is not armed, made while bit 1 is 0, updates the other bits and leaves bit 1 unchanged.
- R7: The arm is spent by one control write. A second control write cannot change bit 1.
- R8: A wrong key value, or an unlock register written out of turn, returns the tracker to idle.
- R9: Writing 0x00007123 to 0x18 at any step, including while armed, restarts the sequence as if it were its first word.
- R10: Unlock registers (0x18, 0x1C) always accept writes and read back as zero.
- R11: Control stores bits 0, 1 and 3 to 8. Bit 2 and bits 9 to 31 read zero.
- R12: Writes to unmapped offsets (such as 0x10, 0x14, 0x30) are not accepted, set no error and change nothing.
- R13: Status and other register writes between key words do not disturb the tracker. Any control write returns the tracker to idle, which cancels a partial sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for the offset on addr_i |
| accept_o | output | 1 | The current write takes effect |
| ctrl_o | output | 9 | Stored control bits 8:0 |
| wp_err_o | output | 1 | Sticky write-protect error |

## Verification
Two events can coincide in one cycle.

The first is a write of the first key while the tracker waits for a later word. The sequence is aborted and restarted in the same cycle. The vector table provokes this by repeating the first two keys before the final one. The check is that the single trailing final key is enough to let the next control write change the protect flag.

The second is a blocked register write arriving while a key sequence is half done. It must raise the error and still leave the tracker's progress intact. The check is that the following final key arms the gate.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTRL_W = 9;
  localparam int unsigned WP_BIT = 1;
  localparam int unsigned ERR_BIT = 1;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 9'h1FB;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 9'h002;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_UNL1   = 8'h18;
  localparam logic [7:0] OFS_UNL2   = 8'h1C;
  localparam logic [7:0] OFS_STATUS = 8'h2C;
  localparam int unsigned TIMING_BASE = 'h04;
  localparam int unsigned NUM_TIMING  = 3;
  localparam int unsigned PROG_BASE   = 'h20;
  localparam int unsigned NUM_PROG    = 3;
  localparam int unsigned REG_STRIDE  = 4;

  localparam logic [DATA_W-1:0] KEY_A = 32'h0000_7123;
  localparam logic [DATA_W-1:0] KEY_B = 32'h0000_812A;
  localparam logic [DATA_W-1:0] KEY_C = 32'h0000_BEE1;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_KEY1  = 2'd1,
    SEQ_KEY2  = 2'd2,
    SEQ_ARMED = 2'd3
  } seq_e;

  typedef struct packed {
    logic ctrl;
    logic gated;
    logic status;
    logic unl1;
    logic unl2;
  } sel_t;
endpackage

// File: rtl/wpg_decode.sv
module wpg_decode
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o
);
  logic [NUM_TIMING-1:0] t_hit;
  logic [NUM_PROG-1:0]   p_hit;

  for (genvar i = 0; i < NUM_TIMING; i++) begin : g_tim
    assign t_hit[i] = (addr_i == ADDR_W'(TIMING_BASE + REG_STRIDE * i));
  end

  for (genvar j = 0; j < NUM_PROG; j++) begin : g_prog
    assign p_hit[j] = (addr_i == ADDR_W'(PROG_BASE + REG_STRIDE * j));
  end

  assign sel_o.ctrl   = (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_o.gated  = (|t_hit) | (|p_hit);
  assign sel_o.status = (addr_i == ADDR_W'(OFS_STATUS));
  assign sel_o.unl1   = (addr_i == ADDR_W'(OFS_UNL1));
  assign sel_o.unl2   = (addr_i == ADDR_W'(OFS_UNL2));
endmodule

// File: rtl/wpg_unlock_seq.sv
module wpg_unlock_seq
  import wpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_unl1_i,
  input  logic              wr_unl2_i,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              armed_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_ctrl_i) begin
      state_d = SEQ_IDLE;
    end else if (wr_unl1_i) begin
      if (state_q == SEQ_KEY2 && wdata_i == KEY_C) state_d = SEQ_ARMED;
      else if (wdata_i == KEY_A)                   state_d = SEQ_KEY1;  // restart
      else                                         state_d = SEQ_IDLE;
    end else if (wr_unl2_i) begin
      state_d = (state_q == SEQ_KEY1 && wdata_i == KEY_B) ? SEQ_KEY2 : SEQ_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o = (state_q == SEQ_ARMED);
endmodule

// File: rtl/wpg_ctrl_reg.sv
module wpg_ctrl_reg
  import wpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              armed_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              wp_o
);
  logic [CTRL_W-1:0] ctrl_q, wr_val;

  always_comb begin
    wr_val = wdata_i & CTRL_MASK;
    if (!armed_i) wr_val[WP_BIT] = ctrl_q[WP_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  ctrl_q <= CTRL_RST;
    else if (wr_i && (!ctrl_q[WP_BIT] || armed_i)) ctrl_q <= wr_val;
  end

  assign ctrl_o = ctrl_q;
  assign wp_o   = ctrl_q[WP_BIT];
endmodule

// File: rtl/wpg_status.sv
module wpg_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_o <= 1'b0;
    else if (set_i) err_o <= 1'b1;
    else if (clr_i) err_o <= 1'b0;
  end
endmodule

// File: rtl/regbank_wp_gate.sv
module regbank_wp_gate
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  output logic              accept_o,
  output logic [8:0]        ctrl_o,
  output logic              wp_err_o
);
  sel_t              sel;
  logic              armed;
  logic              wp;
  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ctrl, blocked_wr;

  wpg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr_ctrl    = we_i & sel.ctrl;
  assign blocked_wr = we_i & wp & ((sel.ctrl & ~armed) | sel.gated);
  assign accept_o   = we_i & ((sel.ctrl & (~wp | armed)) | (sel.gated & ~wp)
                              | sel.status | sel.unl1 | sel.unl2);

  wpg_unlock_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_unl1_i (we_i & sel.unl1),
    .wr_unl2_i (we_i & sel.unl2),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (wdata_i),
    .armed_o   (armed)
  );

  wpg_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ctrl),
    .armed_i (armed),
    .wdata_i (wdata_i[CTRL_W-1:0]),
    .ctrl_o  (ctrl_q),
    .wp_o    (wp)
  );

  wpg_status u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (blocked_wr),
    .clr_i  (we_i & sel.status & wdata_i[ERR_BIT]),
    .err_o  (wp_err_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel.ctrl)        rdata_o[CTRL_W-1:0] = ctrl_q;
    else if (sel.status) rdata_o[ERR_BIT]    = wp_err_o;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/wpg_chk.sv
module wpg_chk
  import wpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              clr_bit_i,
  input logic              we_i,
  input logic [31:0]       rdata_o,
  input logic [8:0]        ctrl_o,
  input logic              wp_err_o,
  input logic              armed_i
);
  localparam logic [ADDR_W-1:0] SPARE_OFS = ADDR_W'(8'h10);

  // R3
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_err_o && !(we_i && addr_i == ADDR_W'(OFS_STATUS) && clr_bit_i)) |=> wp_err_o);

  // R6
  wp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> $stable(ctrl_o[WP_BIT]));

  // R2
  ctrl_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[WP_BIT] && !armed_i && we_i && addr_i == ADDR_W'(OFS_CTRL))
      |=> ($stable(ctrl_o) && wp_err_o));

  // R7
  arm_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && we_i && addr_i == ADDR_W'(OFS_CTRL)) |=> !armed_i);

  // R10
  unl_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_UNL1) || addr_i == ADDR_W'(OFS_UNL2)) |-> rdata_o == '0);

  // R12
  unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SPARE_OFS && !wp_err_o) |=> (!wp_err_o && $stable(ctrl_o)));
endmodule

bind regbank_wp_gate wpg_chk #(.ADDR_W(ADDR_W)) u_wpg_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .clr_bit_i (wdata_i[1]),
  .we_i      (we_i),
  .rdata_o   (rdata_o),
  .ctrl_o    (ctrl_o),
  .wp_err_o  (wp_err_o),
  .armed_i   (armed)
);

// File: tb/regbank_wp_gate_test.sv
module regbank_wp_gate_test;
  localparam int CLK_P = 10;
  localparam int NV = 49;

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        acc;
    logic [8:0]  ctrl;
    logic        err;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{4'd2,  8'h04, 32'h0000_0055, 1'b0, 9'h002, 1'b1}, // R2 timing blocked
    '{4'd3,  8'h20, 32'h0000_0000, 1'b0, 9'h002, 1'b1}, // R3 sticky
    '{4'd4,  8'h2C, 32'h0000_0000, 1'b1, 9'h002, 1'b1}, // R4 zero no effect
    '{4'd4,  8'h2C, 32'h0000_0002, 1'b1, 9'h002, 1'b0}, // R4 clear
    '{4'd2,  8'h00, 32'h0000_01F0, 1'b0, 9'h002, 1'b1}, // R2 control blocked
    '{4'd4,  8'h2C, 32'hFFFF_FFFF, 1'b1, 9'h002, 1'b0},
    '{4'd12, 8'h10, 32'h0000_00FF, 1'b0, 9'h002, 1'b0}, // R12
    '{4'd12, 8'h30, 32'h0000_00FF, 1'b0, 9'h002, 1'b0}, // R12
    '{4'd10, 8'h18, 32'h0000_7123, 1'b1, 9'h002, 1'b0}, // R10 R5
    '{4'd10, 8'h1C, 32'h0000_812A, 1'b1, 9'h002, 1'b0},
    '{4'd5,  8'h18, 32'h0000_BEE1, 1'b1, 9'h002, 1'b0},
    '{4'd5,  8'h00, 32'h0000_0081, 1'b1, 9'h081, 1'b0}, // R5 WP cleared
    '{4'd6,  8'h00, 32'h0000_00FE, 1'b1, 9'h0F8, 1'b0}, // R6 WP held at 0
    '{4'd2,  8'h08, 32'h0000_1234, 1'b1, 9'h0F8, 1'b0}, // R2 open
    '{4'd11, 8'h00, 32'hFFFF_FFFF, 1'b1, 9'h1F9, 1'b0}, // R11 mask
    '{4'd8,  8'h18, 32'h0000_7124, 1'b1, 9'h1F9, 1'b0}, // R8 wrong value
    '{4'd8,  8'h1C, 32'h0000_812A, 1'b1, 9'h1F9, 1'b0},
    '{4'd8,  8'h18, 32'h0000_BEE1, 1'b1, 9'h1F9, 1'b0},
    '{4'd8,  8'h00, 32'h0000_0002, 1'b1, 9'h000, 1'b0}, // R8 not armed
    '{4'd8,  8'h18, 32'h0000_7123, 1'b1, 9'h000, 1'b0}, // R8 out of turn
    '{4'd8,  8'h18, 32'h0000_BEE1, 1'b1, 9'h000, 1'b0},
    '{4'd8,  8'h1C, 32'h0000_812A, 1'b1, 9'h000, 1'b0},
    '{4'd8,  8'h18, 32'h0000_BEE1, 1'b1, 9'h000, 1'b0},
    '{4'd8,  8'h00, 32'h0000_0002, 1'b1, 9'h000, 1'b0},
    '{4'd9,  8'h18, 32'h0000_7123, 1'b1, 9'h000, 1'b0}, // R9 restart
    '{4'd9,  8'h1C, 32'h0000_812A, 1'b1, 9'h000, 1'b0},
    '{4'd9,  8'h18, 32'h0000_7123, 1'b1, 9'h000, 1'b0},
    '{4'd9,  8'h1C, 32'h0000_812A, 1'b1, 9'h000, 1'b0},
    '{4'd9,  8'h18, 32'h0000_BEE1, 1'b1, 9'h000, 1'b0},
    '{4'd9,  8'h00, 32'h0000_0003, 1'b1, 9'h003, 1'b0},
    '{4'd7,  8'h00, 32'h0000_0000, 1'b0, 9'h003, 1'b1}, // R7 spent
    '{4'd4,  8'h2C, 32'h0000_0002, 1'b1, 9'h003, 1'b0},
    '{4'd13, 8'h18, 32'h0000_7123, 1'b1, 9'h003, 1'b0}, // R13 interleave
    '{4'd13, 8'h2C, 32'h0000_0002, 1'b1, 9'h003, 1'b0},
    '{4'd13, 8'h1C, 32'h0000_812A, 1'b1, 9'h003, 1'b0},
    '{4'd13, 8'h04, 32'h0000_0001, 1'b0, 9'h003, 1'b1},
    '{4'd13, 8'h18, 32'h0000_BEE1, 1'b1, 9'h003, 1'b1},
    '{4'd13, 8'h00, 32'h0000_0000, 1'b1, 9'h000, 1'b1},
    '{4'd13, 8'h18, 32'h0000_7123, 1'b1, 9'h000, 1'b1}, // R13 cancel
    '{4'd13, 8'h1C, 32'h0000_812A, 1'b1, 9'h000, 1'b1},
    '{4'd13, 8'h00, 32'h0000_0002, 1'b1, 9'h000, 1'b1},
    '{4'd13, 8'h18, 32'h0000_BEE1, 1'b1, 9'h000, 1'b1},
    '{4'd13, 8'h00, 32'h0000_0002, 1'b1, 9'h000, 1'b1},
    '{4'd7,  8'h18, 32'h0000_7123, 1'b1, 9'h000, 1'b1}, // R7 set WP
    '{4'd7,  8'h1C, 32'h0000_812A, 1'b1, 9'h000, 1'b1},
    '{4'd7,  8'h18, 32'h0000_BEE1, 1'b1, 9'h000, 1'b1},
    '{4'd7,  8'h00, 32'h0000_0002, 1'b1, 9'h002, 1'b1},
    '{4'd7,  8'h00, 32'h0000_0000, 1'b0, 9'h002, 1'b1},
    '{4'd4,  8'h2C, 32'h0000_0002, 1'b1, 9'h002, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        accept;
  logic [8:0]  ctrl;
  logic        err;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  regbank_wp_gate #(.ADDR_W(8)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .we_i     (we),
    .rdata_o  (rdata),
    .accept_o (accept),
    .ctrl_o   (ctrl),
    .wp_err_o (err)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(string req, logic [7:0] a, logic [31:0] d, logic exp_acc);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    #(CLK_P/4);
    chk(req, "accept", 32'(accept), 32'(exp_acc));
    @(posedge clk);
    #(CLK_P/4);
    we = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a; we = 1'b0;
    #(CLK_P/4);
    chk(req, "rdata", rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R1 reset state
    chk("R1", "ctrl", 32'(ctrl), 32'h002);
    chk("R1", "err", 32'(err), 32'h0);
    rst_n = 1'b1;
    rd("R1", 8'h00, 32'h0000_0002);
    rd("R1", 8'h2C, 32'h0000_0000);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].req);
      wr(tag, VEC[i].addr, VEC[i].wdata, VEC[i].acc);
      chk(tag, "ctrl", 32'(ctrl), 32'(VEC[i].ctrl));
      chk(tag, "err", 32'(err), 32'(VEC[i].err));
    end

    // R3 status readback after blocked write
    wr("R3", 8'h28, 32'h0000_0004, 1'b0);
    rd("R3", 8'h2C, 32'h0000_0002);
    // R11 control readback
    rd("R11", 8'h00, 32'h0000_0002);
    // R10 unlock readback
    wr("R10", 8'h1C, 32'hFFFF_FFFF, 1'b1);
    rd("R10", 8'h1C, 32'h0000_0000);
    rd("R10", 8'h18, 32'h0000_0000);
    // R12 unmapped offset leaves error state and control as they were
    wr("R12", 8'h14, 32'h0000_0000, 1'b0);
    chk("R12", "err", 32'(err), 32'h1);
    rd("R12", 8'h00, 32'h0000_0002);

    // R1 mid-run reset drops an arm
    wr("R1", 8'h2C, 32'h0000_0002, 1'b1);
    wr("R1", 8'h18, 32'h0000_7123, 1'b1);
    wr("R1", 8'h1C, 32'h0000_812A, 1'b1);
    wr("R1", 8'h18, 32'h0000_BEE1, 1'b1);
    wr("R1", 8'h00, 32'h0000_0000, 1'b1);
    chk("R1", "ctrl", 32'(ctrl), 32'h000);
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_P/4);
    chk("R1", "ctrl", 32'(ctrl), 32'h002);
    @(negedge clk);
    rst_n = 1'b1;
    wr("R1", 8'h00, 32'h0000_0000, 1'b0);
    chk("R1", "ctrl", 32'(ctrl), 32'h002);
    chk("R1", "err", 32'(err), 32'h1);

    finish_run();
  end
endmodule